// File: doc/BRIEF.md
# SMBus Host Register File

This block is the host-facing register file of an SMBus host controller. Software reaches it through a byte-wide read/write bus with a small offset. It holds a status byte, a control byte, a command byte, a target address byte, two data bytes and a 32-entry block buffer. A host-side pointer selects the current buffer entry, and every block access advances it.

Writing the control register with its launch bit set sends a single-cycle start pulse to a separate transaction engine. The engine reads the command, address, data and buffer contents from dedicated outputs. It returns results through an update port: the two data bytes, single buffer entries, and an error indication that is latched into status. Several accesses have side effects. A status write clears status and rewinds the block pointer. A control read returns a masked value and also rewinds the pointer.

Top module: `smbh_regs`

## Requirements
- R1: After reset, every register reads zero, the block pointer is at entry 0 and the start pulse is low.
- R2: Only the low 6 bits of the bus offset are decoded. The decoded offsets are status 0x00, control 0x02, command 0x03, address 0x04, data0 0x05, data1 0x06 and block port 0x07. Any other offset reads as 0x00, and a write to it changes nothing.
- R3: Any write to status clears the whole status byte and sets the block pointer to 0, whatever value is written.
- R4: A control write stores all 8 bits, which appear on `ctlOut`. If bit 6 of the written byte is 1, `startPulse` is high for exactly the one cycle after the write edge.
- R5: A control read returns the stored control byte ANDed with 0x1f, and sets the block pointer to 0.
- R6: A block-port write stores the byte at the pointer and then advances the pointer. After entry 31 the pointer wraps to entry 0.
- R7: A block-port read returns the byte at the pointer and then advances the pointer, with the same wrap after entry 31.
- R8: The command, address, data0 and data1 registers read back the last value written, and they drive `cmdOut`, `addrOut`, `data0Out` and `data1Out`.
- R9: A cycle with `engErr` high sets status bit 2 (value 0x04). The bit stays set until a status write in a later cycle. If a status write and `engErr` fall in the same cycle, the bit ends up set.
- R10: Engine updates to data0, data1 and one buffer entry take priority over host writes in the same cycle. A host block write that collides with an engine buffer write is dropped, but the pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busOfs | input | OFS_W | Register offset; only the low 6 bits are decoded |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from the offset |
| startPulse | output | 1 | One-cycle transaction launch |
| ctlOut | output | 8 | Full control byte |
| cmdOut | output | 8 | Command byte |
| addrOut | output | 8 | Target address byte |
| data0Out | output | 8 | Data0 byte |
| data1Out | output | 8 | Data1 byte |
| blkRdIdx | input | 5 | Engine read index into the block buffer |
| blkRdData | output | 8 | Buffer entry at blkRdIdx |
| engD0Wr | input | 1 | Engine writes data0 |
| engD0 | input | 8 | Engine data0 value (also the block count) |
| engD1Wr | input | 1 | Engine writes data1 |
| engD1 | input | 8 | Engine data1 value |
| engBlkWr | input | 1 | Engine writes one buffer entry |
| engBlkIdx | input | 5 | Engine buffer write index |
| engBlkData | input | 8 | Engine buffer write data |
| engErr | input | 1 | Engine reports an unsupported protocol |

## Verification
The hardest cases to reach are collisions between the engine update port and a host access in the same clock. One is an error report landing on a status clear. The other is an engine buffer write landing on a host block write. The bench forces each collision by driving the bus and the engine inputs on the same falling edge. It then reads the results back through the normal ports: status, the block port after a rewind, and the engine read index. Pointer wrap is reached by walking more than 32 consecutive block accesses in each direction.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int DEC_W = 6;

  localparam logic [DEC_W-1:0] OFS_STAT = 6'h00;
  localparam logic [DEC_W-1:0] OFS_CTL  = 6'h02;
  localparam logic [DEC_W-1:0] OFS_CMD  = 6'h03;
  localparam logic [DEC_W-1:0] OFS_ADDR = 6'h04;
  localparam logic [DEC_W-1:0] OFS_D0   = 6'h05;
  localparam logic [DEC_W-1:0] OFS_D1   = 6'h06;
  localparam logic [DEC_W-1:0] OFS_BLK  = 6'h07;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_CTL, SEL_CMD, SEL_ADDR, SEL_D0, SEL_D1, SEL_BLK
  } rdSel_e;

  typedef struct packed {
    logic   wrStat;
    logic   wrCtl;
    logic   wrCmd;
    logic   wrAddr;
    logic   wrD0;
    logic   wrD1;
    logic   wrBlk;
    logic   rdCtl;
    logic   rdBlk;
    rdSel_e rdSel;
  } hostStrb_t;
endpackage

// File: rtl/smbh_ctrl.sv
module smbh_ctrl
  import smbh_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [OFS_W-1:0] busOfs,
  input  logic             launchBit,
  output hostStrb_t        strb,
  output logic             startPulse
);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(6'h3f);

  logic [DEC_W-1:0] ofsM;
  logic             startQ;

  assign ofsM = DEC_W'(busOfs & OFS_MASK);

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    case (ofsM)
      OFS_STAT: begin
        strb.rdSel  = SEL_STAT;
        strb.wrStat = busSel && busWr;
      end
      OFS_CTL: begin
        strb.rdSel = SEL_CTL;
        strb.wrCtl = busSel && busWr;
        strb.rdCtl = busSel && !busWr;
      end
      OFS_CMD: begin
        strb.rdSel = SEL_CMD;
        strb.wrCmd = busSel && busWr;
      end
      OFS_ADDR: begin
        strb.rdSel  = SEL_ADDR;
        strb.wrAddr = busSel && busWr;
      end
      OFS_D0: begin
        strb.rdSel = SEL_D0;
        strb.wrD0  = busSel && busWr;
      end
      OFS_D1: begin
        strb.rdSel = SEL_D1;
        strb.wrD1  = busSel && busWr;
      end
      OFS_BLK: begin
        strb.rdSel = SEL_BLK;
        strb.wrBlk = busSel && busWr;
        strb.rdBlk = busSel && !busWr;
      end
      default: strb.rdSel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) startQ <= 1'b0;
    else       startQ <= strb.wrCtl && launchBit;
  end

  assign startPulse = startQ;

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStat, strb.wrCtl, strb.wrCmd, strb.wrAddr, strb.wrD0,
              strb.wrD1, strb.wrBlk, strb.rdCtl, strb.rdBlk})); // R2
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> $past(busSel && busWr && ofsM == OFS_CTL)); // R4
  AST_START_ONLY_CTL: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && ofsM == OFS_CTL) |=> !startQ); // R4
endmodule

// File: rtl/smbh_dpath.sv
module smbh_dpath
  import smbh_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BLK_DEPTH = 32,
  parameter int ERR_BIT   = 2,
  parameter int IDX_W     = $clog2(BLK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrb_t         strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] ctlOut,
  output logic [DATA_W-1:0] cmdOut,
  output logic [DATA_W-1:0] addrOut,
  output logic [DATA_W-1:0] data0Out,
  output logic [DATA_W-1:0] data1Out,
  input  logic [IDX_W-1:0]  blkRdIdx,
  output logic [DATA_W-1:0] blkRdData,
  input  logic              engD0Wr,
  input  logic [DATA_W-1:0] engD0,
  input  logic              engD1Wr,
  input  logic [DATA_W-1:0] engD1,
  input  logic              engBlkWr,
  input  logic [IDX_W-1:0]  engBlkIdx,
  input  logic [DATA_W-1:0] engBlkData,
  input  logic              engErr
);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(BLK_DEPTH - 1);
  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'(8'h1f);

  logic [DATA_W-1:0] statQ, ctlQ, cmdQ, addrQ, d0Q, d1Q;
  logic [DATA_W-1:0] blkMem [BLK_DEPTH];
  logic [IDX_W-1:0]  idxQ;
  logic              hostBlkWr;

  assign hostBlkWr = strb.wrBlk && !engBlkWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      ctlQ  <= '0;
      cmdQ  <= '0;
      addrQ <= '0;
      d0Q   <= '0;
      d1Q   <= '0;
    end else begin
      if (strb.wrStat) statQ <= '0;
      if (engErr)      statQ[ERR_BIT] <= 1'b1;
      if (strb.wrCtl)  ctlQ  <= busWdata;
      if (strb.wrCmd)  cmdQ  <= busWdata;
      if (strb.wrAddr) addrQ <= busWdata;
      if (engD0Wr)         d0Q <= engD0;
      else if (strb.wrD0)  d0Q <= busWdata;
      if (engD1Wr)         d1Q <= engD1;
      else if (strb.wrD1)  d1Q <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (strb.wrStat || strb.rdCtl) begin
      idxQ <= '0;
    end else if (strb.wrBlk || strb.rdBlk) begin
      idxQ <= (idxQ == IDX_LAST) ? '0 : idxQ + 1'b1;
    end
  end

  for (genvar g = 0; g < BLK_DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        blkMem[g] <= '0;
      end else if (engBlkWr && engBlkIdx == IDX_W'(g)) begin
        blkMem[g] <= engBlkData;
      end else if (hostBlkWr && idxQ == IDX_W'(g)) begin
        blkMem[g] <= busWdata;
      end
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STAT: busRdata = statQ;
      SEL_CTL:  busRdata = ctlQ & CTL_MASK;
      SEL_CMD:  busRdata = cmdQ;
      SEL_ADDR: busRdata = addrQ;
      SEL_D0:   busRdata = d0Q;
      SEL_D1:   busRdata = d1Q;
      SEL_BLK:  busRdata = blkMem[idxQ];
      default:  busRdata = '0;
    endcase
  end

  assign blkRdData = blkMem[blkRdIdx];
  assign ctlOut    = ctlQ;
  assign cmdOut    = cmdQ;
  assign addrOut   = addrQ;
  assign data0Out  = d0Q;
  assign data1Out  = d1Q;

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && !engErr) |=> statQ == '0); // R3
  AST_IDX_CLR_STAT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStat |=> idxQ == '0); // R3
  AST_IDX_CLR_CTL: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCtl |=> idxQ == '0); // R5
  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCtl |-> busRdata[DATA_W-1:5] == '0); // R5
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrStat || strb.rdCtl || strb.wrBlk || strb.rdBlk) |=> $stable(idxQ)); // R6
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rdBlk || strb.wrBlk) && idxQ == IDX_LAST) |=> idxQ == '0); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[ERR_BIT] && !strb.wrStat) |=> statQ[ERR_BIT]); // R9
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    engErr |=> statQ[ERR_BIT]); // R9
  AST_ENG_D0_WINS: assert property (@(posedge clk) disable iff (!rstN)
    engD0Wr |=> d0Q == $past(engD0)); // R10
endmodule

// File: rtl/smbh_regs.sv
module smbh_regs
  import smbh_pkg::*;
#(
  parameter int OFS_W     = 8,
  parameter int BLK_DEPTH = 32,
  parameter int IDX_W     = $clog2(BLK_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [OFS_W-1:0] busOfs,
  input  logic [7:0]       busWdata,
  output logic [7:0]       busRdata,
  output logic             startPulse,
  output logic [7:0]       ctlOut,
  output logic [7:0]       cmdOut,
  output logic [7:0]       addrOut,
  output logic [7:0]       data0Out,
  output logic [7:0]       data1Out,
  input  logic [IDX_W-1:0] blkRdIdx,
  output logic [7:0]       blkRdData,
  input  logic             engD0Wr,
  input  logic [7:0]       engD0,
  input  logic             engD1Wr,
  input  logic [7:0]       engD1,
  input  logic             engBlkWr,
  input  logic [IDX_W-1:0] engBlkIdx,
  input  logic [7:0]       engBlkData,
  input  logic             engErr
);
  localparam int LAUNCH_BIT = 6;

  hostStrb_t strb;

  smbh_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busOfs     (busOfs),
    .launchBit  (busWdata[LAUNCH_BIT]),
    .strb       (strb),
    .startPulse (startPulse)
  );

  smbh_dpath #(.DATA_W(8), .BLK_DEPTH(BLK_DEPTH), .ERR_BIT(2), .IDX_W(IDX_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .ctlOut     (ctlOut),
    .cmdOut     (cmdOut),
    .addrOut    (addrOut),
    .data0Out   (data0Out),
    .data1Out   (data1Out),
    .blkRdIdx   (blkRdIdx),
    .blkRdData  (blkRdData),
    .engD0Wr    (engD0Wr),
    .engD0      (engD0),
    .engD1Wr    (engD1Wr),
    .engD1      (engD1),
    .engBlkWr   (engBlkWr),
    .engBlkIdx  (engBlkIdx),
    .engBlkData (engBlkData),
    .engErr     (engErr)
  );
endmodule

// File: tb/smbh_regs_tb.sv
module smbh_regs_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busOfs = '0, busWdata = '0;
  logic [7:0] busRdata;
  logic       startPulse;
  logic [7:0] ctlOut, cmdOut, addrOut, data0Out, data1Out, blkRdData;
  logic [4:0] blkRdIdx = '0, engBlkIdx = '0;
  logic       engD0Wr = 1'b0, engD1Wr = 1'b0, engBlkWr = 1'b0, engErr = 1'b0;
  logic [7:0] engD0 = '0, engD1 = '0, engBlkData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  smbh_regs u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busOfs(busOfs),
    .busWdata(busWdata), .busRdata(busRdata), .startPulse(startPulse),
    .ctlOut(ctlOut), .cmdOut(cmdOut), .addrOut(addrOut), .data0Out(data0Out),
    .data1Out(data1Out), .blkRdIdx(blkRdIdx), .blkRdData(blkRdData),
    .engD0Wr(engD0Wr), .engD0(engD0), .engD1Wr(engD1Wr), .engD1(engD1),
    .engBlkWr(engBlkWr), .engBlkIdx(engBlkIdx), .engBlkData(engBlkData),
    .engErr(engErr)
  );

  // {write, offset, data, expected read}
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h03, 8'hA5, 8'h00},  // R8 command
    {1'b0, 8'h03, 8'h00, 8'hA5},
    {1'b1, 8'h04, 8'h3C, 8'h00},
    {1'b0, 8'h44, 8'h00, 8'h3C},  // R2 0x44 aliases address
    {1'b1, 8'h05, 8'h11, 8'h00},
    {1'b0, 8'h05, 8'h00, 8'h11},
    {1'b1, 8'h06, 8'h22, 8'h00},
    {1'b0, 8'h06, 8'h00, 8'h22},
    {1'b1, 8'h01, 8'hFF, 8'h00},  // R2 undecoded
    {1'b0, 8'h01, 8'h00, 8'h00},
    {1'b1, 8'h08, 8'h77, 8'h00},
    {1'b0, 8'h08, 8'h00, 8'h00},
    {1'b0, 8'h03, 8'h00, 8'hA5},
    {1'b1, 8'h43, 8'h5A, 8'h00},  // R2 0x43 aliases command
    {1'b0, 8'h03, 8'h00, 8'h5A},
    {1'b1, 8'h02, 8'h9B, 8'h00},  // R5 no launch bit
    {1'b0, 8'h02, 8'h00, 8'h1B},
    {1'b1, 8'h07, 8'h10, 8'h00},  // R6 R7
    {1'b1, 8'h07, 8'h20, 8'h00},
    {1'b0, 8'h02, 8'h00, 8'h1B},
    {1'b0, 8'h07, 8'h00, 8'h10}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] ofs, input logic [7:0] val);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busOfs = ofs; busWdata = val;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] ofs, output logic [7:0] val);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busOfs = ofs;
    #1 val = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 startPulse", {7'b0, startPulse}, 8'h00);
    check("R1 ctlOut", ctlOut, 8'h00);
    check("R1 data0Out", data0Out, 8'h00);
    busRead(8'h00, rd); check("R1 status", rd, 8'h00);
    busRead(8'h07, rd); check("R1 block entry0", rd, 8'h00);

    // table walk (R2 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) busWrite(VEC[i][23:16], VEC[i][15:8]);
      else begin
        busRead(VEC[i][23:16], rd);
        check($sformatf("R2/R8 vector %0d", i), rd, VEC[i][7:0]);
      end
    end
    busRead(8'h07, rd); check("R7 second block entry", rd, 8'h20);
    check("R8 cmdOut", cmdOut, 8'h5A);
    check("R8 addrOut", addrOut, 8'h3C);
    check("R8 data1Out", data1Out, 8'h22);

    // R4 launch pulse
    busWrite(8'h02, 8'hDF);
    check("R4 startPulse high", {7'b0, startPulse}, 8'h01);
    check("R4 ctlOut full byte", ctlOut, 8'hDF);
    @(negedge clk);
    check("R4 startPulse one cycle", {7'b0, startPulse}, 8'h00);
    busRead(8'h02, rd); check("R5 ctl masked", rd, 8'h1F);

    // R3 status write rewinds pointer
    busWrite(8'h07, 8'h55);          // pointer now past entry 0
    busWrite(8'h00, 8'h00);
    busWrite(8'h07, 8'h66);          // lands on entry 0
    blkRdIdx = 5'd0; #1;
    check("R3 pointer rewound by status write", blkRdData, 8'h66);

    // R6 write wrap
    busWrite(8'h00, 8'hFF);
    for (int i = 0; i < 32; i++) busWrite(8'h07, 8'((i * 7) + 3));
    busWrite(8'h07, 8'hEE);
    blkRdIdx = 5'd0; #1; check("R6 write wrapped to entry0", blkRdData, 8'hEE);
    blkRdIdx = 5'd1; #1; check("R6 entry1 untouched", blkRdData, 8'h0A);
    blkRdIdx = 5'd31; #1; check("R6 entry31", blkRdData, 8'(31 * 7 + 3));

    // R7 read wrap
    busRead(8'h02, rd);
    for (int i = 0; i < 32; i++) begin
      busRead(8'h07, rd);
      check($sformatf("R7 block read %0d", i), rd, (i == 0) ? 8'hEE : 8'((i * 7) + 3));
    end
    busRead(8'h07, rd); check("R7 read wrapped to entry0", rd, 8'hEE);

    // R9 error sticky
    @(negedge clk); engErr = 1'b1;
    @(negedge clk); engErr = 1'b0;
    busRead(8'h00, rd); check("R9 error set", rd, 8'h04);
    repeat (3) @(negedge clk);
    busRead(8'h00, rd); check("R9 error sticky", rd, 8'h04);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busOfs = 8'h00; busWdata = 8'hFF; engErr = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; engErr = 1'b0;
    busRead(8'h00, rd); check("R9 error wins same-cycle clear", rd, 8'h04);
    busWrite(8'h00, 8'h04);
    busRead(8'h00, rd); check("R3 status cleared", rd, 8'h00);

    // R10 engine priority
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busOfs = 8'h05; busWdata = 8'h99;
    engD0Wr = 1'b1; engD0 = 8'h42; engD1Wr = 1'b1; engD1 = 8'h24;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; engD0Wr = 1'b0; engD1Wr = 1'b0;
    busRead(8'h05, rd); check("R10 engine data0 wins", rd, 8'h42);
    check("R10 engine data1", data1Out, 8'h24);
    busWrite(8'h00, 8'h00);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busOfs = 8'h07; busWdata = 8'hAB;
    engBlkWr = 1'b1; engBlkIdx = 5'd0; engBlkData = 8'hCD;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; engBlkWr = 1'b0;
    busWrite(8'h07, 8'h12);
    busRead(8'h02, rd);
    busRead(8'h07, rd); check("R10 engine buffer write wins", rd, 8'hCD);
    busRead(8'h07, rd); check("R10 pointer still advanced", rd, 8'h12);
    @(negedge clk);
    engBlkWr = 1'b1; engBlkIdx = 5'd9; engBlkData = 8'h3E;
    @(negedge clk);
    engBlkWr = 1'b0;
    blkRdIdx = 5'd9; #1; check("R10 engine writes entry9", blkRdData, 8'h3E);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule